// File: doc/BRIEF.md
# LCD Frame Timing and Blink Unit

This block turns a 32768 Hz clock-enable strobe into the timing of a segment LCD. A prescaler and a clock divider produce one pulse per common phase. The phase index walks through the configured number of commons, and each wrap marks the start of a new frame. The frame rate is therefore the tick rate divided by the prescaler ratio, by (divider + 1) and by the number of phases.

Three frame counters count frames and pulse an event when they overflow. The overflow value is a 5-bit field scaled by eight, so an event comes once every (value × 8 + 1) frames. Any counter can drive the blink unit. The blink unit holds a visible/hidden phase that flips on each event from its chosen counter. While the phase is hidden it masks either every segment or only selected segments of the first two segment lines. The masked segment data leaves on a per-segment visibility vector. A segment that is stored as off is never turned on.

Top module: `lcd_frame_blink`

## Requirements
- R1: A phase pulse `phase_adv_o` is produced once every P × (ckdiv_i + 1) accepted ticks. P is 16, 32, 64 or 128 for `presc_sel_i` codes 0, 1, 2 and 3. A cycle in which `tick_i` is low advances nothing.
- R2: `phase_idx_o` steps 0, 1, …, duty_i and then back to 0, once per phase pulse. The number of phases is duty_i + 1.
- R3: `frame_start_o` pulses together with the phase pulse that wraps the index to 0. Successive frame starts are P × (ckdiv_i + 1) × (duty_i + 1) ticks apart.
- R4: An enabled frame counter k pulses `fc_evt_o[k]` together with `frame_start_o` once every (OVF × 8 + 1) frames. A disabled counter holds its count at zero and emits no event.
- R5: A write to counter k's overflow value through `fc_wr_i`/`fc_wr_idx_i`/`fc_wr_ovf_i` takes effect only while `fc_en_i[k]` is low. Otherwise it is ignored.
- R6: While `blink_en_i` is high, the blink phase flips in the cycle after each event of the counter chosen by the blink select code (0–2). Code 3 never flips it. While `blink_en_i` is low, the phase returns to visible.
- R7: In the hidden phase, mode 0 clears every bit of `seg_vis_o`. Mode 1 clears only bit c×NSEG+0 where select0[c] is 1 and bit c×NSEG+1 where select1[c] is 1, with c the common index 0–7. In the visible phase, `seg_vis_o` equals `seg_on_i`.
- R8: A bit of `seg_vis_o` is never 1 where the same bit of `seg_on_i` is 0.
- R9: Blink configuration (mode, counter select, both select bytes) is written by `blink_wr_i` only while `blink_en_i` is low. Otherwise the write is ignored.
- R10: After reset all pulses are low and the phase index is 0. The blink phase is visible, every overflow value is 0, and the blink configuration is mode 0, counter 0, with no selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | 32768 Hz clock-enable strobe |
| presc_sel_i | input | 2 | Prescaler code (÷16/32/64/128) |
| ckdiv_i | input | 3 | Clock divider value, divides by value + 1 |
| duty_i | input | 3 | Number of common phases minus one |
| fc_en_i | input | 3 | Enable of each frame counter |
| fc_wr_i | input | 1 | Overflow-value write strobe |
| fc_wr_idx_i | input | 2 | Frame counter addressed by the write |
| fc_wr_ovf_i | input | 5 | Overflow value to write |
| blink_en_i | input | 1 | Blink enable |
| blink_wr_i | input | 1 | Blink configuration write strobe |
| blink_mode_i | input | 1 | 0 = all segments, 1 = selected segments |
| blink_fcs_i | input | 2 | Frame counter driving the blink (3 = none) |
| blink_sel0_i | input | 8 | Select of segment line 0, bit per common |
| blink_sel1_i | input | 8 | Select of segment line 1, bit per common |
| seg_on_i | input | 32 | Stored segment states, bit c×NSEG+s |
| phase_adv_o | output | 1 | One-cycle pulse per common phase |
| phase_idx_o | output | 3 | Current common phase |
| frame_start_o | output | 1 | One-cycle pulse at each frame start |
| fc_evt_o | output | 3 | Overflow event of each frame counter |
| seg_vis_o | output | 32 | Segment states after blink masking |

## Verification
The bench goes after the divider chain when ticks come with gaps: a design that counts clock cycles instead of ticks runs fast. It also checks the ×8+1 overflow spacing; an off-by-one shows up as 8 or 10 frames where 9 are expected. Writes are issued into an enabled counter and an enabled blink unit. A design without the lock changes the event spacing or the blink mask part-way through a run. Blink mode 1 is compared against a mask the bench builds itself, and counter code 3 against a phase that never flips. Mapping the selects to the wrong bits, or blinking segments that are off, changes `seg_vis_o` in a cycle the reference model predicts exactly.

// File: rtl/lfb_pkg.sv
// Package: shared types and helpers of the LCD frame timing and blink unit.
// Assumes prescaler codes select 16 shifted left by the code.
package lfb_pkg;

    localparam int PRESC_W    = 8;
    localparam int PRESC_BASE = 16;

    typedef enum logic {
        BLINK_ALL = 1'b0,
        BLINK_SEL = 1'b1
    } blink_mode_e;

    // Division ratio selected by a prescaler code.
    function automatic logic [PRESC_W-1:0] presc_div(input logic [1:0] code);
        return PRESC_W'(PRESC_BASE) << code;
    endfunction

endpackage

// File: rtl/lfb_rate_gen.sv
// Module: rate generator. Divides the tick strobe by the prescaler and the
// clock divider into phase pulses, walks the phase index and flags frames.
// Assumes configuration is quasi-static; a shrinking limit wraps at once.
module lfb_rate_gen #(
    parameter int CKDIV_W = 3,
    parameter int DUTY_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic [1:0]         presc_sel_i,
    input  logic [CKDIV_W-1:0] ckdiv_i,
    input  logic [DUTY_W-1:0]  duty_i,
    output logic               frame_pulse_o,
    output logic               phase_adv_o,
    output logic               frame_start_o,
    output logic [DUTY_W-1:0]  phase_idx_o
);
    localparam int PCW = lfb_pkg::PRESC_W - 1;

    logic [PCW-1:0]             pcnt_q;
    logic [CKDIV_W-1:0]         dcnt_q;
    logic [DUTY_W-1:0]          phase_q;
    logic [lfb_pkg::PRESC_W-1:0] plim;
    logic p_last, d_last, ph_last;
    logic padv_q, frame_q;

    // Terminal-count decode of the three counting stages.
    always_comb begin
        plim    = lfb_pkg::presc_div(presc_sel_i);
        p_last  = ({1'b0, pcnt_q} >= (plim - 1'b1));
        d_last  = (dcnt_q >= ckdiv_i);
        ph_last = (phase_q >= duty_i);
    end

    assign frame_pulse_o = tick_i & p_last & d_last & ph_last;

    // Prescaler, divider and phase counters, advanced only on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q  <= '0;
            dcnt_q  <= '0;
            phase_q <= '0;
        end else if (tick_i) begin
            if (p_last) begin
                pcnt_q <= '0;
                if (d_last) begin
                    dcnt_q  <= '0;
                    phase_q <= ph_last ? '0 : phase_q + 1'b1;
                end else begin
                    dcnt_q <= dcnt_q + 1'b1;
                end
            end else begin
                pcnt_q <= pcnt_q + 1'b1;
            end
        end
    end

    // Registered phase and frame pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            padv_q  <= 1'b0;
            frame_q <= 1'b0;
        end else begin
            padv_q  <= tick_i & p_last & d_last;
            frame_q <= frame_pulse_o;
        end
    end

    assign phase_adv_o   = padv_q;
    assign frame_start_o = frame_q;
    assign phase_idx_o   = phase_q;

    p_no_tick_no_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick_i) |-> !phase_adv_o);
    p_frame_on_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_o |-> (phase_adv_o && phase_idx_o == '0));
    p_step_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_adv_o && !frame_start_o) |-> (phase_idx_o != '0));

endmodule

// File: rtl/lfb_frame_ctr.sv
// Module: one frame counter. Counts frame pulses up to OVF*8 and emits a
// one-cycle event on wrap. Holds its overflow value while enabled.
// Assumes frame_i is a single-cycle pulse.
module lfb_frame_ctr #(
    parameter int OVF_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             frame_i,
    input  logic             wr_i,
    input  logic [OVF_W-1:0] ovf_i,
    output logic             evt_o
);
    localparam int CNT_W = OVF_W + 3;

    logic [OVF_W-1:0] ovf_q;
    logic [CNT_W-1:0] cnt_q;
    logic             evt_q;
    logic             wrap;

    assign wrap = (cnt_q >= {ovf_q, 3'b000});

    // Overflow value: accepted only while the counter is idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_q <= '0;
        else if (wr_i && !en_i)
            ovf_q <= ovf_i;
    end

    // Frame count and overflow event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            evt_q <= 1'b0;
        end else if (!en_i) begin
            cnt_q <= '0;
            evt_q <= 1'b0;
        end else begin
            evt_q <= frame_i & wrap;
            if (frame_i)
                cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

    assign evt_o = evt_q;

    p_idle_no_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_i) |-> !evt_o);
    p_ovf_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_i) |-> $stable(ovf_q));

endmodule

// File: rtl/lfb_blink.sv
// Module: blink unit. Keeps a visible/hidden phase flipped by the chosen
// counter's event and masks stored-on segments while hidden.
// Assumes segment bit c*NSEG+s; NSEG is at least 2.
module lfb_blink #(
    parameter int NCOM = 8,
    parameter int NSEG = 4,
    parameter int NFC  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_i,
    input  logic                 wr_i,
    input  logic                 mode_i,
    input  logic [$clog2(NFC+1)-1:0] fcs_i,
    input  logic [NCOM-1:0]      sel0_i,
    input  logic [NCOM-1:0]      sel1_i,
    input  logic [NFC-1:0]       evt_i,
    input  logic [NCOM*NSEG-1:0] seg_on_i,
    output logic [NCOM*NSEG-1:0] seg_vis_o
);
    localparam int FIW  = $clog2(NFC + 1);
    localparam int NBIT = NCOM * NSEG;

    lfb_pkg::blink_mode_e mode_q;
    logic [FIW-1:0]       fcs_q;
    logic [NCOM-1:0]      sel0_q, sel1_q;
    logic                 visible_q;
    logic [(1<<FIW)-1:0]  evt_pad;
    logic                 sel_evt;
    logic [NBIT-1:0]      sel_mask, blank;

    // Event of the selected counter; codes past the last counter stay low.
    always_comb begin
        evt_pad          = '0;
        evt_pad[NFC-1:0] = evt_i;
        sel_evt          = evt_pad[fcs_q];
    end

    // Configuration: writable only while blink is off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= lfb_pkg::BLINK_ALL;
            fcs_q  <= '0;
            sel0_q <= '0;
            sel1_q <= '0;
        end else if (wr_i && !en_i) begin
            mode_q <= lfb_pkg::blink_mode_e'(mode_i);
            fcs_q  <= fcs_i;
            sel0_q <= sel0_i;
            sel1_q <= sel1_i;
        end
    end

    // Blink phase: flips on events, forced visible while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            visible_q <= 1'b1;
        else if (!en_i)
            visible_q <= 1'b1;
        else if (sel_evt)
            visible_q <= ~visible_q;
    end

    // Per-segment select mask for the first two segment lines.
    for (genvar c = 0; c < NCOM; c++) begin : g_com
        for (genvar s = 0; s < NSEG; s++) begin : g_seg
            if (s == 0) begin : g_s0
                assign sel_mask[c*NSEG+s] = sel0_q[c];
            end else if (s == 1) begin : g_s1
                assign sel_mask[c*NSEG+s] = sel1_q[c];
            end else begin : g_none
                assign sel_mask[c*NSEG+s] = 1'b0;
            end
        end
    end

    // Blank vector and masked output.
    always_comb begin
        if (visible_q)
            blank = '0;
        else if (mode_q == lfb_pkg::BLINK_ALL)
            blank = '1;
        else
            blank = sel_mask;
        seg_vis_o = seg_on_i & ~blank;
    end

    p_visible_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_i) |-> visible_q);
    p_cfg_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_i) |-> $stable({mode_q, fcs_q, sel0_q, sel1_q}));

endmodule

// File: rtl/lcd_frame_blink.sv
// Module: top of the LCD frame timing and blink unit. Ties the rate
// generator, NFC frame counters and the blink unit together.
// Assumes tick_i is a single-cycle clock enable at the LCD source rate.
module lcd_frame_blink #(
    parameter int NCOM    = 8,
    parameter int NSEG    = 4,
    parameter int NFC     = 3,
    parameter int OVF_W   = 5,
    parameter int CKDIV_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick_i,
    input  logic [1:0]                presc_sel_i,
    input  logic [CKDIV_W-1:0]        ckdiv_i,
    input  logic [$clog2(NCOM)-1:0]   duty_i,
    input  logic [NFC-1:0]            fc_en_i,
    input  logic                      fc_wr_i,
    input  logic [$clog2(NFC+1)-1:0]  fc_wr_idx_i,
    input  logic [OVF_W-1:0]          fc_wr_ovf_i,
    input  logic                      blink_en_i,
    input  logic                      blink_wr_i,
    input  logic                      blink_mode_i,
    input  logic [$clog2(NFC+1)-1:0]  blink_fcs_i,
    input  logic [NCOM-1:0]           blink_sel0_i,
    input  logic [NCOM-1:0]           blink_sel1_i,
    input  logic [NCOM*NSEG-1:0]      seg_on_i,
    output logic                      phase_adv_o,
    output logic [$clog2(NCOM)-1:0]   phase_idx_o,
    output logic                      frame_start_o,
    output logic [NFC-1:0]            fc_evt_o,
    output logic [NCOM*NSEG-1:0]      seg_vis_o
);
    localparam int DUTY_W = $clog2(NCOM);
    localparam int FIW    = $clog2(NFC + 1);

    logic frame_pulse;

    lfb_rate_gen #(.CKDIV_W(CKDIV_W), .DUTY_W(DUTY_W)) rate_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .presc_sel_i  (presc_sel_i),
        .ckdiv_i      (ckdiv_i),
        .duty_i       (duty_i),
        .frame_pulse_o(frame_pulse),
        .phase_adv_o  (phase_adv_o),
        .frame_start_o(frame_start_o),
        .phase_idx_o  (phase_idx_o)
    );

    for (genvar k = 0; k < NFC; k++) begin : g_fc
        lfb_frame_ctr #(.OVF_W(OVF_W)) ctr_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (fc_en_i[k]),
            .frame_i(frame_pulse),
            .wr_i   (fc_wr_i && (fc_wr_idx_i == FIW'(k))),
            .ovf_i  (fc_wr_ovf_i),
            .evt_o  (fc_evt_o[k])
        );
    end

    lfb_blink #(.NCOM(NCOM), .NSEG(NSEG), .NFC(NFC)) blink_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (blink_en_i),
        .wr_i     (blink_wr_i),
        .mode_i   (blink_mode_i),
        .fcs_i    (blink_fcs_i),
        .sel0_i   (blink_sel0_i),
        .sel1_i   (blink_sel1_i),
        .evt_i    (fc_evt_o),
        .seg_on_i (seg_on_i),
        .seg_vis_o(seg_vis_o)
    );

    p_event_with_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|fc_evt_o) |-> frame_start_o);
    p_off_stays_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_vis_o & ~seg_on_i) == '0);

endmodule

// File: tb/lcd_frame_blink_tb_top.sv
`timescale 1ns/1ps
module lcd_frame_blink_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic [1:0]  presc_sel = 2'd1;
    logic [2:0]  ckdiv = 3'd7;
    logic [2:0]  duty = 3'd3;
    logic [2:0]  fc_en = 3'b000;
    logic        fc_wr = 1'b0;
    logic [1:0]  fc_idx = 2'd0;
    logic [4:0]  fc_ovf = 5'd0;
    logic        bl_en = 1'b0;
    logic        bl_wr = 1'b0;
    logic        bl_mode = 1'b0;
    logic [1:0]  bl_fcs = 2'd0;
    logic [7:0]  bl_s0 = 8'h00;
    logic [7:0]  bl_s1 = 8'h00;
    logic [31:0] seg_on = 32'hF0F0_3C5A;

    logic        phase_adv_o, frame_start_o;
    logic [2:0]  phase_idx_o, fc_evt_o;
    logic [31:0] seg_vis_o;

    always #5 clk = ~clk;

    lcd_frame_blink dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .presc_sel_i(presc_sel),
        .ckdiv_i(ckdiv), .duty_i(duty), .fc_en_i(fc_en), .fc_wr_i(fc_wr),
        .fc_wr_idx_i(fc_idx), .fc_wr_ovf_i(fc_ovf), .blink_en_i(bl_en),
        .blink_wr_i(bl_wr), .blink_mode_i(bl_mode), .blink_fcs_i(bl_fcs),
        .blink_sel0_i(bl_s0), .blink_sel1_i(bl_s1), .seg_on_i(seg_on),
        .phase_adv_o(phase_adv_o), .phase_idx_o(phase_idx_o),
        .frame_start_o(frame_start_o), .fc_evt_o(fc_evt_o), .seg_vis_o(seg_vis_o)
    );

    int n_chk = 0, n_err = 0, cyc = 0;
    bit done = 0, cmp_on = 0, gap_mode = 0;
    int gcnt = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int  m_pc, m_dc, m_ph;
    int  m_fc[3];
    int  m_ovf[3];
    bit  m_padv, m_frm, m_vis, m_mode;
    bit [2:0] m_evt;
    int  m_fcs;
    bit [7:0] m_s0, m_s1;

    always @(posedge clk) begin : mdl
        bit f;
        bit [2:0] oe;
        int lim;
        cyc++;
        if (!rst_n) begin
            m_pc = 0; m_dc = 0; m_ph = 0; m_padv = 0; m_frm = 0; m_evt = 0;
            for (int k = 0; k < 3; k++) begin m_fc[k] = 0; m_ovf[k] = 0; end
            m_vis = 1; m_mode = 0; m_fcs = 0; m_s0 = 0; m_s1 = 0;
        end else begin
            oe = m_evt; m_padv = 0; f = 0;
            if (tick) begin
                lim = 16 * (1 << presc_sel);
                if (m_pc + 1 >= lim) begin
                    m_pc = 0;
                    if (m_dc + 1 >= int'(ckdiv) + 1) begin
                        m_dc = 0; m_padv = 1;
                        if (m_ph + 1 >= int'(duty) + 1) begin m_ph = 0; f = 1; end
                        else m_ph++;
                    end else m_dc++;
                end else m_pc++;
            end
            m_frm = f;
            for (int k = 0; k < 3; k++) begin
                m_evt[k] = 0;
                if (!fc_en[k]) begin
                    m_fc[k] = 0;
                    if (fc_wr && int'(fc_idx) == k) m_ovf[k] = int'(fc_ovf);
                end else if (f) begin
                    if (m_fc[k] == m_ovf[k] * 8) begin m_fc[k] = 0; m_evt[k] = 1; end
                    else m_fc[k]++;
                end
            end
            if (!bl_en) begin
                m_vis = 1;
                if (bl_wr) begin m_mode = bl_mode; m_fcs = int'(bl_fcs); m_s0 = bl_s0; m_s1 = bl_s1; end
            end else if (m_fcs < 3 && oe[m_fcs]) begin
                m_vis = !m_vis;
            end
        end
    end

    function automatic logic [31:0] sel_mask(input bit [7:0] s0, input bit [7:0] s1);
        logic [31:0] m = '0;
        for (int c = 0; c < 8; c++) begin m[c*4] = s0[c]; m[c*4+1] = s1[c]; end
        return m;
    endfunction

    function automatic logic [31:0] exp_vis();
        logic [31:0] m;
        m = m_mode ? sel_mask(m_s0, m_s1) : 32'hFFFF_FFFF;
        return m_vis ? seg_on : (seg_on & ~m);
    endfunction

    // Every-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk("R1", "phase_adv", 32'(phase_adv_o), 32'(m_padv));
            chk("R2", "phase_idx", 32'(phase_idx_o), 32'(m_ph));
            chk("R3", "frame_start", 32'(frame_start_o), 32'(m_frm));
            chk("R4", "fc_evt", 32'(fc_evt_o), 32'(m_evt));
            chk("R7", "seg_vis", seg_vis_o, exp_vis());
            chk("R8", "off_stays_off", seg_vis_o & ~seg_on, 32'h0);
        end
    end

    // Tick source: every cycle, or one in three in gap mode.
    always @(negedge clk) begin
        #1;
        tick = gap_mode ? (gcnt == 0) : 1'b1;
        gcnt = (gcnt + 1) % 3;
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    function automatic bit sig(input int w);
        case (w)
            0, 1, 2: return fc_evt_o[w];
            3:       return frame_start_o;
            default: return phase_adv_o;
        endcase
    endfunction

    // Cycles between two successive pulses of the chosen signal.
    task automatic meas(input int w, output int dt);
        int t0;
        do @(negedge clk); while (!sig(w));
        t0 = cyc;
        do @(negedge clk); while (!sig(w));
        dt = cyc - t0;
    endtask

    task automatic fc_write(input int idx, input int v);
        step(1);
        fc_wr = 1; fc_idx = 2'(idx); fc_ovf = 5'(v);
        step(1);
        fc_wr = 0;
    endtask

    task automatic bl_write(input bit mode, input int fcs, input bit [7:0] s0, input bit [7:0] s1);
        step(1);
        bl_wr = 1; bl_mode = mode; bl_fcs = 2'(fcs); bl_s0 = s0; bl_s1 = s1;
        step(1);
        bl_wr = 0;
    endtask

    task automatic wait_evt(input int k);
        do @(negedge clk); while (!fc_evt_o[k]);
    endtask

    initial begin
        int dt;
        logic [31:0] m;
        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10", "reset phase_adv", 32'(phase_adv_o), 32'h0);
        chk("R10", "reset frame_start", 32'(frame_start_o), 32'h0);
        chk("R10", "reset fc_evt", 32'(fc_evt_o), 32'h0);
        chk("R10", "reset phase_idx", 32'(phase_idx_o), 32'h0);
        chk("R10", "reset seg_vis visible", seg_vis_o, seg_on);
        #1; rst_n = 1; cmp_on = 1;

        // R1/R3: /32, divider 8, four phases -> 1024 ticks per frame
        meas(4, dt); chk("R1", "phase period presc1 ckdiv7", 32'(dt), 32'd256);
        meas(3, dt); chk("R3", "frame period 32*8*4", 32'(dt), 32'd1024);

        // Fastest setting: 16 ticks per frame
        step(1); presc_sel = 0; ckdiv = 0; duty = 0;
        meas(3, dt); chk("R3", "frame period 16*1*1", 32'(dt), 32'd16);
        // R10: counter 0 keeps default overflow 0 -> event every frame
        step(1); fc_en[0] = 1;
        meas(0, dt); chk("R10", "default ovf event each frame", 32'(dt), 32'd16);
        fc_write(1, 1); fc_write(2, 2);
        step(1); fc_en[1] = 1; fc_en[2] = 1;
        meas(1, dt); chk("R4", "ovf 1 -> 9 frames", 32'(dt), 32'd144);
        meas(2, dt); chk("R4", "ovf 2 -> 17 frames", 32'(dt), 32'd272);

        // R5: write while enabled is ignored
        fc_write(1, 3);
        meas(1, dt); chk("R5", "locked ovf keeps 9 frames", 32'(dt), 32'd144);
        step(1); fc_en[1] = 0;
        fc_write(1, 3);
        step(1); fc_en[1] = 1;
        meas(1, dt); chk("R5", "idle write -> 25 frames", 32'(dt), 32'd400);
        step(1); fc_en[1] = 0;
        fc_write(1, 1);
        step(1); fc_en[1] = 1;

        // R7: mode 0 on counter 1 hides everything
        bl_write(0, 1, 8'h00, 8'h00);
        step(1); bl_en = 1;
        wait_evt(1); @(negedge clk);
        chk("R7", "mode0 hidden", seg_vis_o, 32'h0);
        // R9: write during blink is ignored
        #1; bl_write(1, 0, 8'hFF, 8'h00);
        wait_evt(1); @(negedge clk);
        chk("R6", "flip back visible", seg_vis_o, seg_on);
        wait_evt(1); @(negedge clk);
        chk("R9", "cfg locked, still mode0", seg_vis_o, 32'h0);
        // R6: disable returns to visible
        #1; bl_en = 0;
        step(1);
        chk("R6", "disabled -> visible", seg_vis_o, seg_on);

        // R7: mode 1 on counter 0, selects A5 / 0F
        seg_on = 32'hFFFF_FFFF;
        bl_write(1, 0, 8'hA5, 8'h0F);
        step(1); bl_en = 1;
        wait_evt(0); @(negedge clk);
        m = sel_mask(8'hA5, 8'h0F);
        chk("R7", "mode1 selected blank", seg_vis_o, ~m);
        #1; seg_on = 32'h0000_0000;
        step(1);
        chk("R8", "off segments stay off", seg_vis_o, 32'h0);
        seg_on = 32'h3C3C_A5A5;

        // R6: counter code 3 never flips
        step(1); bl_en = 0;
        bl_write(0, 3, 8'h00, 8'h00);
        step(1); bl_en = 1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (seg_vis_o !== seg_on) begin
                chk("R6", "code 3 no flip", seg_vis_o, seg_on);
                break;
            end
        end
        chk("R6", "code 3 still visible", seg_vis_o, seg_on);
        #1; bl_en = 0;

        // R1/R3: ticks with gaps, /16, divider 2, two phases -> 64 ticks
        step(1); presc_sel = 0; ckdiv = 1; duty = 1; gap_mode = 1;
        meas(3, dt); chk("R3", "gapped frame 64 ticks", 32'(dt), 32'd192);
        meas(4, dt); chk("R1", "gapped phase 32 ticks", 32'(dt), 32'd96);

        // R1: prescaler code 3
        step(1); gap_mode = 0; presc_sel = 3; ckdiv = 0; duty = 0;
        meas(3, dt); chk("R1", "presc code 3 -> 128", 32'(dt), 32'd128);
        // R2: eight phases at /64
        step(1); presc_sel = 2; duty = 7;
        meas(3, dt); chk("R2", "eight phases 64*8", 32'(dt), 32'd512);
        // R4: disabled counters stay silent
        step(1); fc_en = 3'b000;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (fc_evt_o != 3'b000) begin chk("R4", "disabled silent", 32'(fc_evt_o), 32'h0); break; end
        end
        chk("R4", "disabled silent end", 32'(fc_evt_o), 32'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule